// File: doc/BRIEF.md
# Address Translation Mode and Root Selector

This block decides, for every memory access, how the access is translated before any page walk starts. It takes the current privilege level, the virtualization flag, the access type and the status fields that can redirect privilege. From these it works out the privilege used for the access and whether translation is an identity map. It also reports whether the guest root register replaces the normal one, and whether the access needs a two-stage (guest then host) lookup.

For each of the two stages it also picks the root page number, the translation mode field and the make-executable-readable flag. These go to a page walker that sits outside this block. The block is purely combinational: every output settles in the same cycle the request is presented.

Privilege encoding: 0 is user, 1 is supervisor, 3 is machine. Access type encoding: 0 is instruction fetch, 1 is load, 2 is store.

Top module: `xlat_mode_sel`

## Requirements
- R1: For a load or store (acc_type_i is 1 or 2) issued in machine privilege (priv_i = 3) with mprv_i set, eff_priv_o equals mpp_i. In that case, if hyp_en_i and mpv_i are both set, guest_root_o is 1.
- R2: After R1 is applied, if the privilege in effect is supervisor (1), hyp_en_i is 1, virt_i is 0, the access is not a fetch and sprv_i is 1, then eff_priv_o becomes {1'b0, spp_i} and guest_root_o is 1.
- R3: For an instruction fetch (acc_type_i = 0), eff_priv_o equals priv_i and guest_root_o is 0, whatever the override fields hold.
- R4: two_stage_o is 1 exactly when one of these holds: virt_i is 1; or hyp_en_i is 1, priv_i is 3, the access is not a fetch, and mprv_i and mpv_i are both 1; or hyp_en_i is 1, priv_i is 1, virt_i is 0, the access is not a fetch, and sprv_i and spv_i are both 1.
- R5: s2_priv_o is always user (0).
- R6: bare_o is 1 exactly when eff_priv_o is 3 or mmu_en_i is 0.
- R7: s1_mxr_o equals mxr_i and s2_mxr_o equals vs_mxr_i.
- R8: s1_root_ppn_o and s1_mode_o come from the guest root inputs (vsatp_*) when guest_root_o is 1, and from the normal root inputs (satp_*) otherwise.
- R9: s2_root_ppn_o and s2_mode_o always come from the G-stage root inputs (hgatp_*).
- R10: Without the hypervisor extension (hyp_en_i = 0), guest_root_o is 0 for every input combination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| priv_i | input | 2 | Current privilege level |
| virt_i | input | 1 | Virtualization active |
| acc_type_i | input | 2 | 0 fetch, 1 load, 2 store |
| hyp_en_i | input | 1 | Hypervisor extension present |
| mmu_en_i | input | 1 | MMU feature present |
| mprv_i | input | 1 | Machine modify-privilege enable |
| mpp_i | input | 2 | Machine previous privilege |
| mpv_i | input | 1 | Machine previous virtualization |
| sprv_i | input | 1 | Hypervisor modify-privilege enable |
| spp_i | input | 1 | Supervisor previous privilege |
| spv_i | input | 1 | Supervisor previous virtualization |
| mxr_i | input | 1 | Main status make-executable-readable flag |
| vs_mxr_i | input | 1 | Guest status make-executable-readable flag |
| satp_ppn_i | input | PPN_W | Normal root page number |
| satp_mode_i | input | MODE_W | Normal root mode field |
| vsatp_ppn_i | input | PPN_W | Guest root page number |
| vsatp_mode_i | input | MODE_W | Guest root mode field |
| hgatp_ppn_i | input | PPN_W | G-stage root page number |
| hgatp_mode_i | input | MODE_W | G-stage root mode field |
| eff_priv_o | output | 2 | Effective privilege for the access |
| bare_o | output | 1 | Identity translation |
| guest_root_o | output | 1 | Guest root used for stage one |
| two_stage_o | output | 1 | Two-stage lookup required |
| s1_root_ppn_o | output | PPN_W | Stage-one root page number |
| s1_mode_o | output | MODE_W | Stage-one mode field |
| s1_mxr_o | output | 1 | Stage-one MXR |
| s2_root_ppn_o | output | PPN_W | Stage-two root page number |
| s2_mode_o | output | MODE_W | Stage-two mode field |
| s2_mxr_o | output | 1 | Stage-two MXR |
| s2_priv_o | output | 2 | Stage-two permission privilege |

## Verification
The assertions assume that every input holds a known 0 or 1 whenever they are evaluated. They also assume that acc_type_i never takes the unused code 3, and that virt_i is only set when hyp_en_i is set. The bench sets every input to a defined value at time zero, before any evaluation happens. It then draws random values with acc_type_i limited to 0 through 2 and virt_i masked by hyp_en_i. The same rules apply to its directed corner cases, such as a machine access whose saved privilege is supervisor, where both overrides apply.

// File: rtl/xlat_mode_pkg.sv
package xlat_mode_pkg;
  typedef enum logic [1:0] {
    PRIV_U = 2'd0,
    PRIV_S = 2'd1,
    PRIV_M = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } acc_e;

  localparam int unsigned NUM_STAGES = 2;
endpackage

// File: rtl/xlat_priv_resolve.sv
module xlat_priv_resolve
  import xlat_mode_pkg::*;
(
  input  logic [1:0] priv_i,
  input  logic       virt_i,
  input  logic [1:0] acc_type_i,
  input  logic       hyp_en_i,
  input  logic       mmu_en_i,
  input  logic       mprv_i,
  input  logic [1:0] mpp_i,
  input  logic       mpv_i,
  input  logic       sprv_i,
  input  logic       spp_i,
  input  logic       spv_i,
  output logic [1:0] eff_priv_o,
  output logic       guest_root_o,
  output logic       two_stage_o,
  output logic       bare_o
);
  logic       not_fetch;
  logic       m_ovr;
  logic       s_ovr;
  logic [1:0] priv_m;

  assign not_fetch = (acc_type_i != ACC_FETCH);

  // machine-level redirect
  assign m_ovr  = (priv_i == PRIV_M) && not_fetch && mprv_i;
  assign priv_m = m_ovr ? mpp_i : priv_i;

  // hypervisor-level redirect, applied on the already-redirected privilege
  assign s_ovr = (priv_m == PRIV_S) && not_fetch && hyp_en_i && !virt_i && sprv_i;

  always_comb begin
    eff_priv_o   = s_ovr ? {1'b0, spp_i} : priv_m;
    guest_root_o = s_ovr || (m_ovr && hyp_en_i && mpv_i);
  end

  assign two_stage_o = virt_i ||
                       (hyp_en_i && m_ovr && mpv_i) ||
                       (hyp_en_i && (priv_i == PRIV_S) && !virt_i && not_fetch && sprv_i && spv_i);

  assign bare_o = (eff_priv_o == PRIV_M) || !mmu_en_i;

  always_comb begin
    if (!hyp_en_i) assert_no_guest_wo_hyp_R10: assert (!guest_root_o);
    if (acc_type_i == ACC_FETCH)
      assert_fetch_keeps_priv_R3: assert (eff_priv_o == priv_i && !guest_root_o);
  end
endmodule

// File: rtl/xlat_root_mux.sv
module xlat_root_mux #(
  parameter int unsigned PPN_W   = 44,
  parameter int unsigned MODE_W  = 4,
  parameter int unsigned STAGE   = 0
) (
  input  logic              use_guest_i,
  input  logic [PPN_W-1:0]  norm_ppn_i,
  input  logic [MODE_W-1:0] norm_mode_i,
  input  logic [PPN_W-1:0]  guest_ppn_i,
  input  logic [MODE_W-1:0] guest_mode_i,
  input  logic [PPN_W-1:0]  gstage_ppn_i,
  input  logic [MODE_W-1:0] gstage_mode_i,
  input  logic              mxr_main_i,
  input  logic              mxr_guest_i,
  output logic [PPN_W-1:0]  ppn_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              mxr_o
);
  generate
    if (STAGE == 0) begin : g_first
      assign ppn_o  = use_guest_i ? guest_ppn_i  : norm_ppn_i;
      assign mode_o = use_guest_i ? guest_mode_i : norm_mode_i;
      assign mxr_o  = mxr_main_i;
    end else begin : g_second
      logic unused;
      assign unused = use_guest_i ^ mxr_main_i ^ (^norm_ppn_i) ^ (^norm_mode_i) ^
                      (^guest_ppn_i) ^ (^guest_mode_i);
      assign ppn_o  = gstage_ppn_i;
      assign mode_o = gstage_mode_i;
      assign mxr_o  = mxr_guest_i;
    end
  endgenerate
endmodule

// File: rtl/xlat_mode_sel.sv
module xlat_mode_sel
  import xlat_mode_pkg::*;
#(
  parameter int unsigned PPN_W  = 44,
  parameter int unsigned MODE_W = 4
) (
  input  logic [1:0]        priv_i,
  input  logic              virt_i,
  input  logic [1:0]        acc_type_i,
  input  logic              hyp_en_i,
  input  logic              mmu_en_i,
  input  logic              mprv_i,
  input  logic [1:0]        mpp_i,
  input  logic              mpv_i,
  input  logic              sprv_i,
  input  logic              spp_i,
  input  logic              spv_i,
  input  logic              mxr_i,
  input  logic              vs_mxr_i,
  input  logic [PPN_W-1:0]  satp_ppn_i,
  input  logic [MODE_W-1:0] satp_mode_i,
  input  logic [PPN_W-1:0]  vsatp_ppn_i,
  input  logic [MODE_W-1:0] vsatp_mode_i,
  input  logic [PPN_W-1:0]  hgatp_ppn_i,
  input  logic [MODE_W-1:0] hgatp_mode_i,
  output logic [1:0]        eff_priv_o,
  output logic              bare_o,
  output logic              guest_root_o,
  output logic              two_stage_o,
  output logic [PPN_W-1:0]  s1_root_ppn_o,
  output logic [MODE_W-1:0] s1_mode_o,
  output logic              s1_mxr_o,
  output logic [PPN_W-1:0]  s2_root_ppn_o,
  output logic [MODE_W-1:0] s2_mode_o,
  output logic              s2_mxr_o,
  output logic [1:0]        s2_priv_o
);
  logic              guest_sel;
  logic [PPN_W-1:0]  st_ppn  [NUM_STAGES];
  logic [MODE_W-1:0] st_mode [NUM_STAGES];
  logic              st_mxr  [NUM_STAGES];

  xlat_priv_resolve u_priv (
    .priv_i       (priv_i),
    .virt_i       (virt_i),
    .acc_type_i   (acc_type_i),
    .hyp_en_i     (hyp_en_i),
    .mmu_en_i     (mmu_en_i),
    .mprv_i       (mprv_i),
    .mpp_i        (mpp_i),
    .mpv_i        (mpv_i),
    .sprv_i       (sprv_i),
    .spp_i        (spp_i),
    .spv_i        (spv_i),
    .eff_priv_o   (eff_priv_o),
    .guest_root_o (guest_sel),
    .two_stage_o  (two_stage_o),
    .bare_o       (bare_o)
  );

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    xlat_root_mux #(.PPN_W(PPN_W), .MODE_W(MODE_W), .STAGE(g)) u_mux (
      .use_guest_i   (guest_sel),
      .norm_ppn_i    (satp_ppn_i),
      .norm_mode_i   (satp_mode_i),
      .guest_ppn_i   (vsatp_ppn_i),
      .guest_mode_i  (vsatp_mode_i),
      .gstage_ppn_i  (hgatp_ppn_i),
      .gstage_mode_i (hgatp_mode_i),
      .mxr_main_i    (mxr_i),
      .mxr_guest_i   (vs_mxr_i),
      .ppn_o         (st_ppn[g]),
      .mode_o        (st_mode[g]),
      .mxr_o         (st_mxr[g])
    );
  end

  assign guest_root_o  = guest_sel;
  assign s1_root_ppn_o = st_ppn[0];
  assign s1_mode_o     = st_mode[0];
  assign s1_mxr_o      = st_mxr[0];
  assign s2_root_ppn_o = st_ppn[1];
  assign s2_mode_o     = st_mode[1];
  assign s2_mxr_o      = st_mxr[1];
  assign s2_priv_o     = PRIV_U;   // stage two checks as user

  always_comb begin
    if (guest_root_o)
      assert_s1_guest_root_R8: assert (s1_root_ppn_o == vsatp_ppn_i && s1_mode_o == vsatp_mode_i);
    else
      assert_s1_norm_root_R8: assert (s1_root_ppn_o == satp_ppn_i && s1_mode_o == satp_mode_i);
    if (eff_priv_o == PRIV_M) assert_machine_is_bare_R6: assert (bare_o);
    if (!hyp_en_i && !virt_i) assert_single_stage_R4: assert (!two_stage_o);
    assert_s2_from_gstage_R9: assert (s2_root_ppn_o == hgatp_ppn_i && s2_mode_o == hgatp_mode_i);
  end
endmodule

// File: tb/xlat_mode_sel_bench.sv
module xlat_mode_sel_bench;
  localparam int PPN_W  = 44;
  localparam int MODE_W = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic [1:0] priv = 2'd3, acc = 2'd1, mpp = 2'd0;
  logic virt = 0, hyp = 0, mmu = 1, mprv = 0, mpv = 0, sprv = 0, spp = 0, spv = 0;
  logic mxr = 0, vmxr = 0;
  logic [PPN_W-1:0]  sppn = '0, vppn = '0, hppn = '0;
  logic [MODE_W-1:0] smode = '0, vmode = '0, hmode = '0;

  logic [1:0] eff_priv, s2_priv;
  logic bare, guest, two, s1_mxr, s2_mxr;
  logic [PPN_W-1:0] s1_ppn, s2_ppn;
  logic [MODE_W-1:0] s1_mode, s2_mode;

  xlat_mode_sel u_xlat_mode_sel (
    .priv_i(priv), .virt_i(virt), .acc_type_i(acc), .hyp_en_i(hyp), .mmu_en_i(mmu),
    .mprv_i(mprv), .mpp_i(mpp), .mpv_i(mpv), .sprv_i(sprv), .spp_i(spp), .spv_i(spv),
    .mxr_i(mxr), .vs_mxr_i(vmxr),
    .satp_ppn_i(sppn), .satp_mode_i(smode), .vsatp_ppn_i(vppn), .vsatp_mode_i(vmode),
    .hgatp_ppn_i(hppn), .hgatp_mode_i(hmode),
    .eff_priv_o(eff_priv), .bare_o(bare), .guest_root_o(guest), .two_stage_o(two),
    .s1_root_ppn_o(s1_ppn), .s1_mode_o(s1_mode), .s1_mxr_o(s1_mxr),
    .s2_root_ppn_o(s2_ppn), .s2_mode_o(s2_mode), .s2_mxr_o(s2_mxr), .s2_priv_o(s2_priv)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference, evaluated on every falling edge
  task automatic compare();
    int p, g, ts, b;
    bit is_fetch;
    is_fetch = (acc == 2'd0);
    p = priv;
    g = 0;
    if (!is_fetch && priv == 3 && mprv) begin
      p = mpp;                                  // R1
      if (hyp && mpv) g = 1;
    end
    if (!is_fetch && p == 1 && hyp && !virt && sprv) begin
      p = spp;                                  // R2
      g = 1;
    end
    ts = 0;
    if (virt) ts = 1;
    if (hyp && !is_fetch && priv == 3 && mprv && mpv) ts = 1;
    if (hyp && !is_fetch && priv == 1 && !virt && sprv && spv) ts = 1;
    b = (p == 3 || !mmu) ? 1 : 0;
    chk("R1/R2/R3 eff_priv", eff_priv, p);
    chk("R1/R2/R3/R10 guest_root", guest, g);
    if (is_fetch) chk("R3 fetch guest_root", guest, 0);
    if (!hyp) chk("R10 no hyp guest_root", guest, 0);
    chk("R4 two_stage", two, ts);
    chk("R5 s2_priv", s2_priv, 0);
    chk("R6 bare", bare, b);
    chk("R7 s1_mxr", s1_mxr, mxr);
    chk("R7 s2_mxr", s2_mxr, vmxr);
    chk("R8 s1_ppn", s1_ppn, g ? vppn : sppn);
    chk("R8 s1_mode", s1_mode, g ? vmode : smode);
    chk("R9 s2_ppn", s2_ppn, hppn);
    chk("R9 s2_mode", s2_mode, hmode);
  endtask

  always @(negedge clk) if (rst_ni && !done) compare();

  task automatic roots();
    sppn  = {$urandom, $urandom};
    vppn  = {$urandom, $urandom};
    hppn  = {$urandom, $urandom};
    smode = 4'($urandom); vmode = 4'($urandom); hmode = 4'($urandom);
  endtask

  task automatic setv(logic [1:0] pr, logic v, logic [1:0] a, logic h, logic mr, logic [1:0] mp,
                      logic mv, logic sr, logic sp, logic sv);
    @(posedge clk);
    priv = pr; virt = v; acc = a; hyp = h; mprv = mr; mpp = mp;
    mpv = mv; sprv = sr; spp = sp; spv = sv;
    roots();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // reset state: machine load, no overrides
    @(negedge clk);
    chk("R6 reset bare", bare, 1);
    chk("R1 reset eff_priv", eff_priv, 3);
    // R1 machine redirect to user with guest root
    setv(2'd3, 0, 2'd1, 1, 1, 2'd0, 1, 0, 0, 0);
    // R1 machine redirect without hyp: no guest root (R10)
    setv(2'd3, 0, 2'd2, 0, 1, 2'd1, 1, 1, 1, 1);
    // R2 chained: MPP=S then SPRV applies
    setv(2'd3, 0, 2'd1, 1, 1, 2'd1, 0, 1, 0, 1);
    // R2 HS sprv with spv -> two stage
    setv(2'd1, 0, 2'd2, 1, 0, 2'd0, 0, 1, 1, 1);
    // R2 blocked by virt
    setv(2'd1, 1, 2'd1, 1, 0, 2'd0, 0, 1, 0, 1);
    // R3 fetches ignore everything
    setv(2'd3, 0, 2'd0, 1, 1, 2'd0, 1, 1, 0, 1);
    setv(2'd1, 0, 2'd0, 1, 1, 2'd3, 1, 1, 0, 1);
    // R6 no MMU
    mmu = 0;
    setv(2'd0, 0, 2'd1, 0, 0, 2'd0, 0, 0, 0, 0);
    mmu = 1;
    // random sweep
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk);
      hyp  = $urandom_range(0, 1);
      virt = hyp & $urandom_range(0, 1);
      priv = 2'($urandom_range(0, 2)); if (priv == 2) priv = 3;
      acc  = 2'($urandom_range(0, 2));
      mprv = $urandom_range(0, 1); mpp = 2'($urandom_range(0, 3));
      mpv  = $urandom_range(0, 1); sprv = $urandom_range(0, 1);
      spp  = $urandom_range(0, 1); spv  = $urandom_range(0, 1);
      mmu  = ($urandom_range(0, 7) != 0);
      mxr  = $urandom_range(0, 1); vmxr = $urandom_range(0, 1);
      roots();
    end
    @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule